// File: doc/BRIEF.md
# Four-Digit Character Display Controller

This block holds the contents of a four-character alphanumeric display and drives them out one digit at a time. A host writes it over a simple asynchronous bus: two active-low chip enables, an active-low write strobe, a two-bit digit address, a cursor-select line and a 7-bit character code. The strobe is brought into the local clock domain. A write is committed when the strobe goes back high, so the host never has to wait for the scan position and may fill the digits in any order.

Inside are two small memories: a character store and a cursor store, one entry per digit. A scanner steps through the digits at a fixed dwell and presents one slot per step. Each slot carries the digit index, the stored code and three flags: dark, fill-all (cursor overlay) and brightness-enable. The brightness-enable toggles from frame to frame under a cursor, which gives half brightness. Three level inputs act on the scan: a clear input sweeps the digits to blank as the scan passes them, a blank input forces the display dark, and a cursor-enable input hides or shows every cursor. None of the three alters the stored characters or cursors, except clear. The font ROM and the LED drive sit outside this block.

Top module: `quad_char_display`

## Requirements
- R1: Each of the four digit addresses (0 = rightmost) keeps its own 7-bit code. The code is shown on `scan_code` while `scan_digit` equals that address, until the address is written again. Writes may arrive in any order.
- R2: A write changes a memory only if both `en_a_n` and `en_b_n` were low in the last sampled cycle with `wr_n` low. If either was high, nothing stored changes.
- R3: Inputs pass through two sampling registers. A write is committed on the second clock edge after the first edge that samples `wr_n` high. It uses the address, select and data of the last low-strobe sample, and appears on the scan outputs one edge later.
- R4: A write with `cur_sel` high sets the addressed digit's cursor bit from `din[0]` (1 sets, 0 clears). `din[6:1]` are ignored and the character code of that digit is unchanged.
- R5: A digit whose cursor bit is set, while the display is lit and `cur_en` is high, is shown with `scan_fill` = 1. Its `scan_bright` follows a frame phase bit that starts at 0 after reset and inverts each time the scan wraps from digit 3 to digit 0, so it alternates on successive frames. The cursor bit persists after the write ends.
- R6: With `cur_en` low, no digit shows fill (`scan_fill` = 0, `scan_bright` = 1 when lit). The cursor bits are kept, so raising `cur_en` again restores the overlay.
- R7: With `blank_n` low, `scan_dark` = 1 and `scan_fill` = `scan_bright` = 0, while neither memory changes. The codes reappear when `blank_n` returns high.
- R8: While the sampled `clr_n` is low, the digit currently under the scan gets the space code 7'h20 and a cleared cursor bit. Clear takes priority over a write in the same cycle. A low level lasting one full frame (4 × DWELL_CYCLES cycles) clears every digit, and a shorter one clears only the digits it passes.
- R9: `scan_digit` stays on each digit for exactly DWELL_CYCLES clocks and then advances by one, wrapping from 3 to 0.
- R10: During and right after reset, `scan_digit` = 0, `scan_code` = 0, `scan_dark` = 1, `scan_fill` = 0 and `scan_bright` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset of scan and sampling state |
| en_a_n | input | 1 | First active-low chip enable |
| en_b_n | input | 1 | Second active-low chip enable |
| wr_n | input | 1 | Active-low write strobe, committed on its rise |
| dig_addr | input | 2 | Digit address, 0 is rightmost |
| cur_sel | input | 1 | High selects the cursor store for this write |
| din | input | 7 | Character code, or cursor value in bit 0 |
| clr_n | input | 1 | Active-low clear, swept with the scan |
| blank_n | input | 1 | Active-low display blank |
| cur_en | input | 1 | High shows stored cursors |
| scan_digit | output | 2 | Digit index of the current slot |
| scan_code | output | 7 | Stored code of that digit |
| scan_dark | output | 1 | Slot is dark |
| scan_fill | output | 1 | Light all dots (cursor overlay) |
| scan_bright | output | 1 | Brightness enable for the slot |

## Verification
A write reaches the scan outputs four edges after the first edge that samples the strobe high: two sampling stages, one memory update and one output register. Clear, blank and cursor-enable act three edges after they are sampled, through two sampling stages and the output register. The bench keeps a short history of sampled inputs and applies each effect at the same edge count. It compares every output at the falling edge that follows, so no result is read before its registers have moved. Directed checks wait for the target digit to come around in the scan before sampling, after allowing the full write latency.

// File: rtl/qdisp_pkg.sv
package qdisp_pkg;
    localparam int unsigned DIGITS = 4;
    localparam int unsigned DIG_W  = $clog2(DIGITS);
    localparam int unsigned CODE_W = 7;
    localparam logic [CODE_W-1:0] SPACE_CODE = 7'h20;

    typedef struct packed {
        logic              wr_n;
        logic              en_a_n;
        logic              en_b_n;
        logic [DIG_W-1:0]  addr;
        logic              cur_sel;
        logic [CODE_W-1:0] data;
        logic              clr_n;
        logic              blank_n;
        logic              cur_en;
    } bus_smp_t;

    localparam bus_smp_t IDLE_SMP = '{
        wr_n: 1'b1, en_a_n: 1'b1, en_b_n: 1'b1, addr: '0, cur_sel: 1'b0,
        data: '0, clr_n: 1'b1, blank_n: 1'b0, cur_en: 1'b0
    };

    typedef struct packed {
        logic [DIG_W-1:0]  digit;
        logic [CODE_W-1:0] code;
        logic              dark;
        logic              fill;
        logic              bright;
    } scan_out_t;

    localparam scan_out_t RESET_OUT = '{
        digit: '0, code: '0, dark: 1'b1, fill: 1'b0, bright: 1'b0
    };
endpackage

// File: rtl/qdisp_bus_sync.sv
module qdisp_bus_sync
    import qdisp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bus_smp_t          raw,
    output logic              wr_cmd,
    output logic              wr_cur,
    output logic [DIG_W-1:0]  wr_addr,
    output logic [CODE_W-1:0] wr_data,
    output logic              clr_act,
    output logic              lit_s,
    output logic              cue_s
);
    typedef struct packed {
        bus_smp_t s1;
        bus_smp_t s2;
        bus_smp_t s3;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{IDLE_SMP, IDLE_SMP, IDLE_SMP};
        end else begin
            st_q <= st_d;
        end
    end

    // Commit on the sampled strobe rise, using the last low-strobe sample.
    assign wr_cmd  = st_q.s2.wr_n & ~st_q.s3.wr_n & ~st_q.s3.en_a_n & ~st_q.s3.en_b_n;
    assign wr_cur  = st_q.s3.cur_sel;
    assign wr_addr = st_q.s3.addr;
    assign wr_data = st_q.s3.data;
    assign clr_act = ~st_q.s2.clr_n;
    assign lit_s   = st_q.s2.blank_n;
    assign cue_s   = st_q.s2.cur_en;

    // R3: a strobe rise commits exactly once
    assert_single_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd |=> !wr_cmd);
endmodule

// File: rtl/qdisp_mem.sv
module qdisp_mem
    import qdisp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_cmd,
    input  logic              wr_cur,
    input  logic [DIG_W-1:0]  wr_addr,
    input  logic [CODE_W-1:0] wr_data,
    input  logic              clr_act,
    input  logic [DIG_W-1:0]  clr_idx,
    input  logic [DIG_W-1:0]  rd_idx,
    output logic [CODE_W-1:0] rd_code,
    output logic              rd_cur
);
    typedef struct packed {
        logic [DIGITS-1:0][CODE_W-1:0] chars;
        logic [DIGITS-1:0]             curs;
    } mem_st_t;

    mem_st_t mem_d, mem_q;

    always_comb begin
        mem_d = mem_q;
        for (int d = 0; d < DIGITS; d++) begin
            if (wr_cmd && (wr_addr == DIG_W'(d))) begin
                if (wr_cur) begin
                    mem_d.curs[d] = wr_data[0];
                end else begin
                    mem_d.chars[d] = wr_data;
                end
            end
            if (clr_act && (clr_idx == DIG_W'(d))) begin
                mem_d.chars[d] = SPACE_CODE;
                mem_d.curs[d]  = 1'b0;
            end
        end
    end

    // Contents are undefined after power-up until a clear has swept them.
    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rd_code = mem_q.chars[rd_idx];
    assign rd_cur  = mem_q.curs[rd_idx];

    // R8: a clearing cycle leaves space and no cursor on the scanned digit
    assert_clear_space_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_act |=> (mem_q.chars[$past(clr_idx)] === SPACE_CODE) && (mem_q.curs[$past(clr_idx)] === 1'b0));

    // R4: a cursor write leaves the character of that digit alone
    assert_cursor_keeps_char_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && wr_cur && !clr_act) |=> (mem_q.chars[$past(wr_addr)] === $past(mem_q.chars[wr_addr])));
endmodule

// File: rtl/qdisp_scan.sv
module qdisp_scan
    import qdisp_pkg::*;
#(
    parameter int unsigned DWELL_CYCLES = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] rd_code,
    input  logic              rd_cur,
    input  logic              lit_s,
    input  logic              cue_s,
    output logic [DIG_W-1:0]  rd_idx,
    output scan_out_t         out
);
    localparam int unsigned      CNT_W    = (DWELL_CYCLES > 1) ? $clog2(DWELL_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DWELL_CYCLES - 1);
    localparam logic [DIG_W-1:0] IDX_LAST = DIG_W'(DIGITS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [DIG_W-1:0] idx;
        logic             phase;
        scan_out_t        out;
    } scan_st_t;

    scan_st_t st_d, st_q;
    logic     show;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == CNT_LAST) begin
            st_d.cnt = '0;
            if (st_q.idx == IDX_LAST) begin
                st_d.idx   = '0;
                st_d.phase = ~st_q.phase;
            end else begin
                st_d.idx = st_q.idx + DIG_W'(1);
            end
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end

        show = rd_cur & cue_s & lit_s;
        st_d.out.digit  = st_q.idx;
        st_d.out.code   = rd_code;
        st_d.out.dark   = ~lit_s;
        st_d.out.fill   = show;
        st_d.out.bright = lit_s & (~(rd_cur & cue_s) | st_q.phase);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, idx: '0, phase: 1'b0, out: RESET_OUT};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_idx = st_q.idx;
    assign out    = st_q.out;

    // R9: digit index only moves forward by one
    assert_digit_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.idx != $past(st_q.idx)) |-> (st_q.idx == $past(st_q.idx) + DIG_W'(1)));

    // R9: no step before the dwell count ends
    assert_dwell_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != CNT_LAST) |=> $stable(st_q.idx));

    // R7: a dark slot lights nothing
    assert_dark_unlit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out.dark |-> (!out.fill && !out.bright));
endmodule

// File: rtl/quad_char_display.sv
module quad_char_display
    import qdisp_pkg::*;
#(
    parameter int unsigned DWELL_CYCLES = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_a_n,
    input  logic              en_b_n,
    input  logic              wr_n,
    input  logic [DIG_W-1:0]  dig_addr,
    input  logic              cur_sel,
    input  logic [CODE_W-1:0] din,
    input  logic              clr_n,
    input  logic              blank_n,
    input  logic              cur_en,
    output logic [DIG_W-1:0]  scan_digit,
    output logic [CODE_W-1:0] scan_code,
    output logic              scan_dark,
    output logic              scan_fill,
    output logic              scan_bright
);
    bus_smp_t          raw_smp;
    logic              wr_cmd, wr_cur, clr_act, lit_s, cue_s, rd_cur;
    logic [DIG_W-1:0]  wr_addr, rd_idx;
    logic [CODE_W-1:0] wr_data, rd_code;
    scan_out_t         slot;

    assign raw_smp = '{
        wr_n: wr_n, en_a_n: en_a_n, en_b_n: en_b_n, addr: dig_addr, cur_sel: cur_sel,
        data: din, clr_n: clr_n, blank_n: blank_n, cur_en: cur_en
    };

    qdisp_bus_sync u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .raw     (raw_smp),
        .wr_cmd  (wr_cmd),
        .wr_cur  (wr_cur),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .clr_act (clr_act),
        .lit_s   (lit_s),
        .cue_s   (cue_s)
    );

    qdisp_mem u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_cmd  (wr_cmd),
        .wr_cur  (wr_cur),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .clr_act (clr_act),
        .clr_idx (rd_idx),
        .rd_idx  (rd_idx),
        .rd_code (rd_code),
        .rd_cur  (rd_cur)
    );

    qdisp_scan #(.DWELL_CYCLES(DWELL_CYCLES)) u_scan (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_code (rd_code),
        .rd_cur  (rd_cur),
        .lit_s   (lit_s),
        .cue_s   (cue_s),
        .rd_idx  (rd_idx),
        .out     (slot)
    );

    assign scan_digit  = slot.digit;
    assign scan_code   = slot.code;
    assign scan_dark   = slot.dark;
    assign scan_fill   = slot.fill;
    assign scan_bright = slot.bright;
endmodule

// File: tb/tb_quad_char_display.sv
module tb_quad_char_display;
    localparam int DW = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_a_n = 1'b1, en_b_n = 1'b1, wr_n = 1'b1, cur_sel = 1'b0;
    logic [1:0] dig_addr = 2'd0;
    logic [6:0] din = 7'd0;
    logic       clr_n = 1'b1, blank_n = 1'b0, cur_en = 1'b0;
    logic [1:0] scan_digit;
    logic [6:0] scan_code;
    logic       scan_dark, scan_fill, scan_bright;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    quad_char_display #(.DWELL_CYCLES(DW)) dut (
        .clk(clk), .rst_n(rst_n), .en_a_n(en_a_n), .en_b_n(en_b_n), .wr_n(wr_n),
        .dig_addr(dig_addr), .cur_sel(cur_sel), .din(din), .clr_n(clr_n),
        .blank_n(blank_n), .cur_en(cur_en), .scan_digit(scan_digit),
        .scan_code(scan_code), .scan_dark(scan_dark), .scan_fill(scan_fill),
        .scan_bright(scan_bright)
    );

    // ---------------- reference model ----------------
    // sample history: index 1 = taken at the previous edge, 2 = two edges back
    int h_wr[1:3], h_ea[1:3], h_eb[1:3], h_ad[1:3], h_cs[1:3], h_dt[1:3];
    int h_cl[1:3], h_bl[1:3], h_ce[1:3];
    int m_char[4], m_cur[4];
    bit m_kc[4], m_kk[4];
    int m_idx, m_cnt, m_phase;
    int e_dig, e_code, e_dark, e_fill, e_bright;
    bit e_kcode, e_kflag;

    task automatic model_reset();
        for (int i = 1; i <= 3; i++) begin
            h_wr[i] = 1; h_ea[i] = 1; h_eb[i] = 1; h_ad[i] = 0; h_cs[i] = 0;
            h_dt[i] = 0; h_cl[i] = 1; h_bl[i] = 0; h_ce[i] = 0;
        end
        m_idx = 0; m_cnt = 0; m_phase = 0;
        e_dig = 0; e_code = 0; e_dark = 1; e_fill = 0; e_bright = 0;
        e_kcode = 1; e_kflag = 1;
    endtask

    initial begin
        for (int d = 0; d < 4; d++) begin
            m_kc[d] = 0; m_kk[d] = 0; m_char[d] = 0; m_cur[d] = 0;
        end
        model_reset();
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            int show;
            // output slot from state before this edge
            e_dig   = m_idx;
            e_code  = m_char[m_idx];
            e_kcode = m_kc[m_idx];
            e_dark  = (h_bl[2] == 0);
            e_kflag = e_dark || m_kk[m_idx];
            show    = (m_cur[m_idx] == 1 && h_ce[2] == 1 && !e_dark) ? 1 : 0;
            e_fill  = show;
            e_bright = e_dark ? 0 : (show ? m_phase : 1);
            // memory: write, then clear wins
            if (h_wr[2] == 1 && h_wr[3] == 0 && h_ea[3] == 0 && h_eb[3] == 0) begin
                if (h_cs[3] == 1) begin
                    m_cur[h_ad[3]] = h_dt[3] % 2; m_kk[h_ad[3]] = 1;
                end else begin
                    m_char[h_ad[3]] = h_dt[3]; m_kc[h_ad[3]] = 1;
                end
            end
            if (h_cl[2] == 0) begin
                m_char[m_idx] = 32; m_cur[m_idx] = 0; m_kc[m_idx] = 1; m_kk[m_idx] = 1;
            end
            // scan
            if (m_cnt == DW - 1) begin
                m_cnt = 0;
                if (m_idx == 3) m_phase = 1 - m_phase;
                m_idx = (m_idx + 1) % 4;
            end else begin
                m_cnt++;
            end
            for (int i = 3; i >= 2; i--) begin
                h_wr[i] = h_wr[i-1]; h_ea[i] = h_ea[i-1]; h_eb[i] = h_eb[i-1];
                h_ad[i] = h_ad[i-1]; h_cs[i] = h_cs[i-1]; h_dt[i] = h_dt[i-1];
                h_cl[i] = h_cl[i-1]; h_bl[i] = h_bl[i-1]; h_ce[i] = h_ce[i-1];
            end
            h_wr[1] = wr_n; h_ea[1] = en_a_n; h_eb[1] = en_b_n; h_ad[1] = dig_addr;
            h_cs[1] = cur_sel; h_dt[1] = din; h_cl[1] = clr_n; h_bl[1] = blank_n;
            h_ce[1] = cur_en;
        end
    end

    task automatic cmp(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // compare every cycle at the falling edge
    always @(negedge clk) begin
        cycles++;
        if (!finished) begin
            cmp("R9", "scan_digit", int'(scan_digit), e_dig);
            cmp("R7", "scan_dark", int'(scan_dark), e_dark);
            if (e_kcode) cmp("R3", "scan_code", int'(scan_code), e_code);
            if (e_kflag) begin
                cmp("R5", "scan_fill", int'(scan_fill), e_fill);
                cmp("R5", "scan_bright", int'(scan_bright), e_bright);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_write(input int a, input bit cs, input int data, input bit ea, input bit eb);
        @(negedge clk);
        dig_addr = 2'(a); cur_sel = cs; din = 7'(data); en_a_n = ea; en_b_n = eb; wr_n = 1'b0;
        idle(3);
        wr_n = 1'b1;
        idle(1);
        en_a_n = 1'b1; en_b_n = 1'b1; cur_sel = 1'b0; din = 7'h7f;
        idle(6);
    endtask

    task automatic wait_visit(input int d);
        while (int'(scan_digit) == d) @(negedge clk);
        while (int'(scan_digit) != d) @(negedge clk);
    endtask

    task automatic expect_slot(input string req, input int d, input int code, input int fill);
        wait_visit(d);
        cmp(req, "directed code", int'(scan_code), code);
        cmp(req, "directed fill", int'(scan_fill), fill);
    endtask

    always @(negedge clk) begin
        if (!finished && cycles > 150000) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int b0, b1, hold, spaces;
        idle(4);
        // R10: reset state
        cmp("R10", "reset digit", int'(scan_digit), 0);
        cmp("R10", "reset dark", int'(scan_dark), 1);
        cmp("R10", "reset code", int'(scan_code), 0);
        cmp("R10", "reset bright", int'(scan_bright), 0);
        rst_n = 1'b1;
        idle(1);
        cmp("R10", "post-reset digit", int'(scan_digit), 0);

        // full-frame clear while blanked
        clr_n = 1'b0;
        idle(4 * DW + 4);
        clr_n = 1'b1;
        idle(4);
        blank_n = 1'b1; cur_en = 1'b1;
        idle(4);
        for (int d = 0; d < 4; d++) expect_slot("R8", d, 32, 0);

        // R9: dwell length
        wait_visit(1);
        hold = 0;
        while (int'(scan_digit) == 1) begin hold++; @(negedge clk); end
        cmp("R9", "dwell cycles", hold, DW);

        // R1: writes in arbitrary order
        bus_write(3, 0, 7'h41, 0, 0);
        bus_write(0, 0, 7'h48, 0, 0);
        bus_write(2, 0, 7'h37, 0, 0);
        bus_write(1, 0, 7'h5a, 0, 0);
        expect_slot("R1", 0, 7'h48, 0);
        expect_slot("R1", 3, 7'h41, 0);
        expect_slot("R1", 1, 7'h5a, 0);

        // R2: one enable high blocks the write
        bus_write(0, 0, 7'h55, 0, 1);
        bus_write(0, 0, 7'h55, 1, 0);
        expect_slot("R2", 0, 7'h48, 0);

        // R4/R5: cursor set, data bits above bit 0 ignored
        bus_write(2, 1, 7'h7f, 0, 0);
        expect_slot("R4", 2, 7'h37, 1);
        b0 = int'(scan_bright);
        wait_visit(2);
        b1 = int'(scan_bright);
        cmp("R5", "bright alternates", b0 ^ b1, 1);

        // R6: cursor enable low hides, high restores
        cur_en = 1'b0;
        idle(4);
        expect_slot("R6", 2, 7'h37, 0);
        cmp("R6", "bright without cursor", int'(scan_bright), 1);
        cur_en = 1'b1;
        idle(4);
        expect_slot("R6", 2, 7'h37, 1);

        // R4: cursor clear restores normal slot
        bus_write(2, 1, 7'h7e, 0, 0);
        expect_slot("R4", 2, 7'h37, 0);

        // R7: blank keeps memory
        blank_n = 1'b0;
        idle(4);
        wait_visit(3);
        cmp("R7", "dark when blanked", int'(scan_dark), 1);
        cmp("R7", "fill when blanked", int'(scan_fill), 0);
        blank_n = 1'b1;
        idle(4);
        expect_slot("R7", 3, 7'h41, 0);

        // R8: short clear pulse covers only some digits
        wait_visit(1);
        clr_n = 1'b0;
        idle(DW);
        clr_n = 1'b1;
        idle(4 * DW + 8);
        spaces = 0;
        for (int d = 0; d < 4; d++) begin
            wait_visit(d);
            if (int'(scan_code) == 32) spaces++;
        end
        cmp("R8", "some digits survive short clear", (spaces >= 1 && spaces <= 2) ? 1 : 0, 1);

        idle(2 * 4 * DW);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule